// File: doc/BRIEF.md
# Banked Stack Control Register File

This block holds a processor's control registers behind one combinational read port and one synchronous write port. A 4-bit register number selects the register on each port. The block stores these registers:

- a status byte, whose top bit is the stack mode;
- a backup status byte and a second-level backup status byte;
- a condition bit;
- two backup program counters;
- two scratch words;
- shadow copies of the interrupt and user stack pointers.

Only one of the two stack pointers is live at a time. The live one sits in the general-purpose stack-pointer register, which this block owns. The block drives that register to the general register file on `sp_live` and accepts register-file writes to it on `sp_wr_en`/`sp_wr_data`.

A status write can change the stack-mode bit. When it does, the live pointer is parked in the shadow of the mode being left, and the shadow of the mode being entered becomes live. Both the swap and the new status commit on the same clock edge.

Register numbers:

| Number | Register |
|---|---|
| 0 | status |
| 1 | second-level backup status |
| 2 | condition |
| 3 | interrupt stack pointer |
| 4 | scratch 0 |
| 5 | scratch 1 |
| 6 | user stack pointer |
| 7 | backup PC |
| 8 | second backup PC |
| 9 to 15 | unlisted |

Top module: `bsr_file`

## Requirements
- R1: After reset every register reads 0 and `sp_live` is 0 (stack mode 0).
- R2: Reading number 0 returns the backup status byte ANDed with 0xC1 in bits 15:8, the status byte ANDed with 0xC0 in bits 7:0 with the condition bit ORed into bit 0, and zero in bits 31:16.
- R3: Writing number 0 loads data bits 15:8 into the backup status byte, loads bits 7:0 into the status byte, and loads bit 0 into the condition bit; bit 7 of the status byte is the stack mode.
- R4: When a write to number 0 changes the stack mode, the old live value goes to the shadow of the old mode (mode 0: interrupt, mode 1: user), and the shadow of the new mode appears on `sp_live` after the same edge.
- R5: Number 3 (interrupt SP) reads and writes the live register in mode 0 and its shadow in mode 1; number 6 (user SP) reads and writes the live register in mode 1 and its shadow in mode 0.
- R6: A write on `sp_wr_en` shows on `sp_live` after the next edge. A control write in the same cycle that swaps, or that writes the live register through number 3 or 6, wins, and the port write is discarded.
- R7: Numbers 7 and 8 store all 32 written bits and read with bit 0 forced to 0.
- R8: Number 1 stores data bits 7:0 and reads them ANDed with 0xC1.
- R9: Number 2 writes and reads only bit 0, the same condition bit seen in bit 0 of number 0.
- R10: Numbers 4 and 5 are plain 32-bit read/write storage.
- R11: Numbers 9 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_sel | input | 4 | Register number for the read port |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| wr_en | input | 1 | Control-register write enable |
| wr_sel | input | 4 | Register number for the write port |
| wr_data | input | 32 | Write data |
| sp_live | output | 32 | Live stack-pointer value |
| sp_wr_en | input | 1 | Register-file write to the live stack pointer |
| sp_wr_data | input | 32 | Data for the live stack pointer |

## Verification
The bench targets mode flips in both directions. A design that swapped in the wrong direction, or let the status commit one edge before the pointers, would show the wrong pointer on `sp_live` or lose a shadow value.

It also checks accesses to numbers 3 and 6 in each mode. A design with inverted selection would write a shadow while the live register stayed stale.

A register-file write that collides with a control write to the live pointer shows whether the wrong source wins. Read masks on the status, backup-status and PC registers expose leaked bits, and writes to unlisted numbers expose any register they corrupt.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int SEL_W    = 4;
    localparam int MODE_BIT = 7;
    localparam logic [7:0] STAT_RD_MASK = 8'hC0;
    localparam logic [7:0] BACK_RD_MASK = 8'hC1;

    typedef enum logic [SEL_W-1:0] {
        CR_STAT = 4'd0,
        CR_BK2  = 4'd1,
        CR_COND = 4'd2,
        CR_ISP  = 4'd3,
        CR_SCR0 = 4'd4,
        CR_SCR1 = 4'd5,
        CR_USP  = 4'd6,
        CR_BPC  = 4'd7,
        CR_BPC2 = 4'd8
    } cr_id_e;
endpackage

// File: rtl/bsr_stack_bank.sv
module bsr_stack_bank #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode,
    input  logic              flip,
    input  logic              isp_wr,
    input  logic              usp_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sp_wr_en,
    input  logic [DATA_W-1:0] sp_wr_data,
    output logic [DATA_W-1:0] live_q,
    output logic [DATA_W-1:0] isp_q,
    output logic [DATA_W-1:0] usp_q
);
    typedef struct packed {
        logic [DATA_W-1:0] live;
        logic [DATA_W-1:0] isp;
        logic [DATA_W-1:0] usp;
    } bank_t;

    bank_t st_d, st_q;
    logic  live_touched;

    always_comb begin
        st_d = st_q;
        live_touched = flip || (isp_wr && !mode) || (usp_wr && mode);
        if (sp_wr_en && !live_touched) begin
            st_d.live = sp_wr_data;
        end
        if (flip) begin
            if (!mode) begin
                st_d.isp  = st_q.live;
                st_d.live = st_q.usp;
            end else begin
                st_d.usp  = st_q.live;
                st_d.live = st_q.isp;
            end
        end else if (isp_wr) begin
            if (!mode) st_d.live = wr_data;
            else       st_d.isp  = wr_data;
        end else if (usp_wr) begin
            if (mode) st_d.live = wr_data;
            else      st_d.usp  = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_q = st_q.live;
    assign isp_q  = st_q.isp;
    assign usp_q  = st_q.usp;
endmodule

// File: rtl/bsr_read_mux.sv
module bsr_read_mux
    import bsr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              mode,
    input  logic [7:0]        stat,
    input  logic [7:0]        bk,
    input  logic [7:0]        bk2,
    input  logic              cond,
    input  logic [DATA_W-1:0] live,
    input  logic [DATA_W-1:0] isp,
    input  logic [DATA_W-1:0] usp,
    input  logic [DATA_W-1:0] bpc,
    input  logic [DATA_W-1:0] bpc2,
    input  logic [DATA_W-1:0] scr0,
    input  logic [DATA_W-1:0] scr1,
    output logic [DATA_W-1:0] data
);
    localparam logic [DATA_W-1:0] PC_MASK = ~{{(DATA_W-1){1'b0}}, 1'b1};

    always_comb begin
        data = '0;
        case (sel)
            CR_STAT: begin
                data[15:8] = bk & BACK_RD_MASK;
                data[7:0]  = (stat & STAT_RD_MASK) | {7'b0, cond};
            end
            CR_BK2:  data[7:0] = bk2 & BACK_RD_MASK;
            CR_COND: data[0]   = cond;
            CR_ISP:  data = mode ? isp : live;
            CR_USP:  data = mode ? live : usp;
            CR_SCR0: data = scr0;
            CR_SCR1: data = scr1;
            CR_BPC:  data = bpc & PC_MASK;
            CR_BPC2: data = bpc2 & PC_MASK;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/bsr_file.sv
module bsr_file
    import bsr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] sp_live,
    input  logic              sp_wr_en,
    input  logic [DATA_W-1:0] sp_wr_data
);
    typedef struct packed {
        logic [7:0]        stat;
        logic [7:0]        bk;
        logic [7:0]        bk2;
        logic              cond;
        logic [DATA_W-1:0] bpc;
        logic [DATA_W-1:0] bpc2;
        logic [DATA_W-1:0] scr0;
        logic [DATA_W-1:0] scr1;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic mode_q;
    logic stat_wr, flip, isp_wr, usp_wr;
    logic [DATA_W-1:0] live_q, isp_sh, usp_sh;

    assign mode_q  = ctl_q.stat[MODE_BIT];
    assign stat_wr = wr_en && (wr_sel == CR_STAT);
    assign flip    = stat_wr && (wr_data[MODE_BIT] != mode_q);
    assign isp_wr  = wr_en && (wr_sel == CR_ISP);
    assign usp_wr  = wr_en && (wr_sel == CR_USP);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            case (wr_sel)
                CR_STAT: begin
                    ctl_d.bk   = wr_data[15:8];
                    ctl_d.stat = wr_data[7:0];
                    ctl_d.cond = wr_data[0];
                end
                CR_BK2:  ctl_d.bk2  = wr_data[7:0];
                CR_COND: ctl_d.cond = wr_data[0];
                CR_SCR0: ctl_d.scr0 = wr_data;
                CR_SCR1: ctl_d.scr1 = wr_data;
                CR_BPC:  ctl_d.bpc  = wr_data;
                CR_BPC2: ctl_d.bpc2 = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    bsr_stack_bank #(.DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_q),
        .flip       (flip),
        .isp_wr     (isp_wr),
        .usp_wr     (usp_wr),
        .wr_data    (wr_data),
        .sp_wr_en   (sp_wr_en),
        .sp_wr_data (sp_wr_data),
        .live_q     (live_q),
        .isp_q      (isp_sh),
        .usp_q      (usp_sh)
    );

    bsr_read_mux #(.DATA_W(DATA_W)) u_rmux (
        .sel  (rd_sel),
        .mode (mode_q),
        .stat (ctl_q.stat),
        .bk   (ctl_q.bk),
        .bk2  (ctl_q.bk2),
        .cond (ctl_q.cond),
        .live (live_q),
        .isp  (isp_sh),
        .usp  (usp_sh),
        .bpc  (ctl_q.bpc),
        .bpc2 (ctl_q.bpc2),
        .scr0 (ctl_q.scr0),
        .scr1 (ctl_q.scr1),
        .data (rd_data)
    );

    assign sp_live = live_q;
endmodule

// File: rtl/bsr_file_chk.sv
module bsr_file_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        rd_sel,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_en,
    input logic [3:0]        wr_sel,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] sp_live,
    input logic              sp_wr_en,
    input logic [DATA_W-1:0] sp_wr_data,
    input logic              mode_q,
    input logic [DATA_W-1:0] isp_q,
    input logic [DATA_W-1:0] usp_q
);
    // R4
    swap_to_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 4'd0 && wr_data[7] && !mode_q)
        |=> (sp_live == $past(usp_q)) && (isp_q == $past(sp_live)) && mode_q);

    // R4
    swap_to_intr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 4'd0 && !wr_data[7] && mode_q)
        |=> (sp_live == $past(isp_q)) && (usp_q == $past(sp_live)) && !mode_q);

    // R6
    sp_port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_wr_en && !wr_en) |=> (sp_live == $past(sp_wr_data)));

    // R6
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_wr_en && !wr_en) |=> $stable(sp_live));

    // R7
    pc_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 4'd7 || rd_sel == 4'd8) |-> (rd_data[0] == 1'b0));

    // R2
    stat_fmt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 4'd0) |-> ((rd_data & ~32'h0000_C1C1) == '0));

    // R11
    unlisted_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel > 4'd8) |-> (rd_data == '0));
endmodule

bind bsr_file bsr_file_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .sp_live    (sp_live),
    .sp_wr_en   (sp_wr_en),
    .sp_wr_data (sp_wr_data),
    .mode_q     (mode_q),
    .isp_q      (isp_sh),
    .usp_q      (usp_sh)
);

// File: tb/bsr_file_bench.sv
`timescale 1ns/1ps
module bsr_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] sp_live;
    logic        sp_wr_en = 1'b0;
    logic [31:0] sp_wr_data = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [7:0]  m_stat = 0, m_bk = 0, m_bk2 = 0;
    logic        m_cond = 0;
    logic [31:0] m_live = 0, m_isp = 0, m_usp = 0;
    logic [31:0] m_bpc = 0, m_bpc2 = 0, m_s0 = 0, m_s1 = 0;

    always #2.5 clk = ~clk;

    bsr_file u_bsr_file (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .sp_live(sp_live),
        .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] s);
        logic md;
        md = m_stat[7];
        case (s)
            4'd0: exp_read = {16'b0, m_bk & 8'hC1, (m_stat & 8'hC0) | {7'b0, m_cond}};
            4'd1: exp_read = {24'b0, m_bk2 & 8'hC1};
            4'd2: exp_read = {31'b0, m_cond};
            4'd3: exp_read = md ? m_isp : m_live;
            4'd4: exp_read = m_s0;
            4'd5: exp_read = m_s1;
            4'd6: exp_read = md ? m_live : m_usp;
            4'd7: exp_read = m_bpc & 32'hFFFF_FFFE;
            4'd8: exp_read = m_bpc2 & 32'hFFFF_FFFE;
            default: exp_read = 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] s);
        case (s)
            4'd0: tag_of = "R2";
            4'd1: tag_of = "R8";
            4'd2: tag_of = "R9";
            4'd3, 4'd6: tag_of = "R5";
            4'd4, 4'd5: tag_of = "R10";
            4'd7, 4'd8: tag_of = "R7";
            default: tag_of = "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic model_update(input logic en, input logic [3:0] s, input logic [31:0] d,
                                input logic spe, input logic [31:0] spd);
        logic md, flip, touched;
        logic [31:0] old_live;
        md = m_stat[7];
        old_live = m_live;
        flip = en && s == 4'd0 && d[7] != md;
        touched = flip || (en && s == 4'd3 && !md) || (en && s == 4'd6 && md);
        if (spe && !touched) m_live = spd;
        if (flip) begin
            if (!md) begin m_isp = old_live; m_live = m_usp; end
            else     begin m_usp = old_live; m_live = m_isp; end
        end
        if (en) begin
            case (s)
                4'd0: begin m_bk = d[15:8]; m_stat = d[7:0]; m_cond = d[0]; end
                4'd1: m_bk2 = d[7:0];
                4'd2: m_cond = d[0];
                4'd3: if (!md) m_live = d; else m_isp = d;
                4'd4: m_s0 = d;
                4'd5: m_s1 = d;
                4'd6: if (md) m_live = d; else m_usp = d;
                4'd7: m_bpc = d;
                4'd8: m_bpc2 = d;
                default: ;
            endcase
        end
    endtask

    task automatic apply(input logic en, input logic [3:0] s, input logic [31:0] d,
                         input logic spe, input logic [31:0] spd);
        @(negedge clk);
        wr_en = en; wr_sel = s; wr_data = d; sp_wr_en = spe; sp_wr_data = spd;
        @(posedge clk);
        model_update(en, s, d, spe, spd);
        #1;
        wr_en = 1'b0; sp_wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [3:0] s, output logic [31:0] v);
        rd_sel = s;
        #0.5;
        v = rd_data;
    endtask

    task automatic check_reg(input string req, input logic [3:0] s, input logic [31:0] exp);
        logic [31:0] v;
        rd(s, v);
        check(req, v, exp);
    endtask

    task automatic check_all(input string req);
        for (int s = 0; s < 16; s++) check_reg(req, 4'(s), exp_read(4'(s)));
        check(req, sp_live, m_live);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int s = 0; s < 16; s++) check_reg("R1", 4'(s), 32'h0);
        check("R1", sp_live, 32'h0);

        // R6: register-file write to the live pointer
        apply(0, 4'd0, 0, 1, 32'h0000_1000);
        check("R6", sp_live, 32'h0000_1000);
        // R5: mode 0 -> interrupt SP is the live register
        apply(1, 4'd3, 32'h0000_2222, 0, 0);
        check("R5", sp_live, 32'h0000_2222);
        apply(1, 4'd6, 32'h0000_3333, 0, 0);
        check("R5", sp_live, 32'h0000_2222);
        check_reg("R5", 4'd6, 32'h0000_3333);
        // R4/R3: flip to mode 1
        apply(1, 4'd0, 32'h0000_8081, 1, 32'h0000_9999);
        check("R4", sp_live, 32'h0000_3333);
        check_reg("R4", 4'd3, 32'h0000_2222);
        check_reg("R2", 4'd0, 32'h0000_8081);
        // R5: mode 1 -> user SP is the live register
        apply(1, 4'd6, 32'h0000_4444, 0, 0);
        check("R5", sp_live, 32'h0000_4444);
        apply(1, 4'd3, 32'h0000_2B2B, 0, 0);
        check_reg("R5", 4'd3, 32'h0000_2B2B);
        // R4/R3: flip back to mode 0, masks on read
        apply(1, 4'd0, 32'h0000_FF3E, 0, 0);
        check("R4", sp_live, 32'h0000_2B2B);
        check_reg("R4", 4'd6, 32'h0000_4444);
        check_reg("R3", 4'd0, 32'h0000_C100);
        // R3: status write with same mode does not swap
        apply(1, 4'd0, 32'h0000_0001, 0, 0);
        check("R3", sp_live, 32'h0000_2B2B);
        check_reg("R3", 4'd2, 32'h1);
        // R6: control write to the live pointer wins over the port
        apply(1, 4'd3, 32'h0000_5555, 1, 32'h0000_6666);
        check("R6", sp_live, 32'h0000_5555);
        // R6: control write to a shadow lets the port write through
        apply(1, 4'd6, 32'h0000_7777, 1, 32'h0000_8888);
        check("R6", sp_live, 32'h0000_8888);
        // R7
        apply(1, 4'd7, 32'hDEAD_BEEF, 0, 0);
        check_reg("R7", 4'd7, 32'hDEAD_BEEE);
        apply(1, 4'd8, 32'h0000_0001, 0, 0);
        check_reg("R7", 4'd8, 32'h0);
        // R8
        apply(1, 4'd1, 32'h0000_01FF, 0, 0);
        check_reg("R8", 4'd1, 32'h0000_00C1);
        // R9
        apply(1, 4'd2, 32'hFFFF_FFFE, 0, 0);
        check_reg("R9", 4'd2, 32'h0);
        apply(1, 4'd2, 32'h0000_0003, 0, 0);
        check_reg("R9", 4'd2, 32'h1);
        check_reg("R9", 4'd0, 32'h0000_0001);
        // R10
        apply(1, 4'd4, 32'hA5A5_A5A5, 0, 0);
        apply(1, 4'd5, 32'h5A5A_5A5A, 0, 0);
        check_reg("R10", 4'd4, 32'hA5A5_A5A5);
        check_reg("R10", 4'd5, 32'h5A5A_5A5A);
        // R11: unlisted writes change nothing
        for (int s = 9; s < 16; s++) apply(1, 4'(s), 32'hFFFF_FFFF, 0, 0);
        check_all("R11");

        // random mix
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  s;
            logic [31:0] d;
            logic [3:0]  rs;
            s = ($urandom % 4 == 0) ? 4'd0 : 4'($urandom % 16);
            d = $urandom;
            apply($urandom % 4 != 0, s, d, $urandom % 3 == 0, $urandom);
            rs = 4'($urandom % 16);
            check_reg(tag_of(rs), rs, exp_read(rs));
            check("R4", sp_live, m_live);
        end
        check_all("R5");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule